// File: doc/BRIEF.md
# Latched Program Counter Unit

This block holds the fetch address of an instruction sequencer as a 21-bit byte address made of three sections: an 8-bit low byte, an 8-bit middle byte (address bits 15:8) and a 5-bit top field (address bits 20:16). Software can reach only the low byte directly. The middle and top sections change in two ways. A direct load can set the whole address. Otherwise they change through two holding latches, and those latches are copied into the counter at the moment the low byte is written. Because of this, a computed jump that builds a full target address takes effect in one step, and the counter never holds a partly updated address.

Reading the low byte copies the current middle and top bytes back into the latches, so a later low-byte write stays in the same region of the address space. Sequential fetch advances the address by one instruction word, which is two bytes. Jump, call and branch targets enter through a direct-load path that skips the latches and leaves their contents unchanged. Address bit 0 is always zero, so the address stays aligned to whole instruction words.

Top module: `pc_latch_unit`

## Requirements
- R1: After reset the fetch address is 0 and both latches hold 0. A low-byte write of value V as the first operation gives the address V with bit 0 cleared.
- R2: `lo_rdata_o` always equals bits 7:0 of the current fetch address, in the same cycle.
- R3: A low-byte write makes the next fetch address equal to {top latch, middle latch, written byte with bit 0 cleared}. The latch values used are those held before that clock edge.
- R4: `mid_latch_wr_i` loads `latch_wdata_i[7:0]` into the middle latch, and `up_latch_wr_i` loads `latch_wdata_i[4:0]` into the top latch. A latch write alone leaves the fetch address unchanged.
- R5: `lo_rd_i` copies address bits 15:8 into the middle latch and bits 20:16 into the top latch. If a latch write strobe is active for a latch in the same cycle, the write wins for that latch.
- R6: Advance adds 2 to the fetch address, modulo 2^21.
- R7: A direct load sets the fetch address to `load_addr_i` with bit 0 cleared. It does not change either latch.
- R8: When several requests arrive in one cycle, direct load beats low-byte write, and low-byte write beats advance.
- R9: Bit 0 of the fetch address is 0 in every cycle.
- R10: With no load, low-byte write or advance, the fetch address holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_rd_i | input | 1 | Low-byte read strobe (captures the upper bytes into the latches) |
| lo_wr_i | input | 1 | Low-byte write strobe (commits the latches) |
| lo_wdata_i | input | 8 | Low-byte write data |
| mid_latch_wr_i | input | 1 | Middle latch write strobe |
| up_latch_wr_i | input | 1 | Top latch write strobe |
| latch_wdata_i | input | 8 | Latch write data |
| load_i | input | 1 | Direct-load strobe for jump, call or branch targets |
| load_addr_i | input | 21 | Direct-load target address |
| adv_i | input | 1 | Advance to the next sequential instruction |
| fetch_addr_o | output | 21 | Current fetch address |
| lo_rdata_o | output | 8 | Low-byte read data |

## Verification
The latches cannot be seen at the ports. A corrupted latch therefore shows up only at the next low-byte write, as wrong bits 20:8 on `fetch_addr_o` one cycle after that write. This can happen many cycles after the fault. The bench therefore follows every latch write and read capture with a commit, so a latch fault becomes visible within a few cycles. A wrong counter state or a wrong priority choice shows on `fetch_addr_o` and `lo_rdata_o` on the very next cycle. The per-cycle comparison against the reference model catches it there.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
   // Source of the next fetch address, chosen by the priority selector.
   typedef enum logic [1:0] {
      SRC_HOLD   = 2'd0,
      SRC_STEP   = 2'd1,
      SRC_COMMIT = 2'd2,
      SRC_LOAD   = 2'd3
   } pcl_src_e;
endpackage

// File: rtl/pcl_src_sel.sv
module pcl_src_sel
   import pcl_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     load_i,
   input  logic     lo_wr_i,
   input  logic     adv_i,
   output pcl_src_e src_o
);
   // Fixed priority: direct load, then low-byte commit, then advance.
   always_comb begin
      if (load_i)       src_o = SRC_LOAD;
      else if (lo_wr_i) src_o = SRC_COMMIT;
      else if (adv_i)   src_o = SRC_STEP;
      else              src_o = SRC_HOLD;
   end

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> src_o == SRC_LOAD); // R8
   AST_COMMIT_OVER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_wr_i && !load_i) |-> src_o == SRC_COMMIT); // R8
endmodule

// File: rtl/pcl_shadow_lane.sv
module pcl_shadow_lane #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   input  logic         cap_i,
   input  logic [W-1:0] cap_data_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_w
      $error("pcl_shadow_lane: W must be at least 1");
   end

   // An explicit write beats a capture in the same cycle.
   always_ff @(posedge clk) begin
      if (!rst_n)     q_o <= '0;
      else if (wr_i)  q_o <= wdata_i;
      else if (cap_i) q_o <= cap_data_i;
   end

   AST_LANE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> q_o == $past(wdata_i)); // R4
   AST_LANE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_i && !wr_i) |=> q_o == $past(cap_data_i)); // R5
   AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_i && !wr_i) |=> $stable(q_o)); // R7
endmodule

// File: rtl/pcl_counter.sv
module pcl_counter
   import pcl_pkg::*;
#(
   parameter int ADDR_W     = 21,
   parameter int LOW_W      = 8,
   parameter int ALIGN_BITS = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  pcl_src_e                src_i,
   input  logic [ADDR_W-1:0]       load_addr_i,
   input  logic [ADDR_W-LOW_W-1:0] commit_hi_i,
   input  logic [LOW_W-1:0]        lo_wdata_i,
   output logic [ADDR_W-1:0]       pc_o
);
   localparam int HI_W = ADDR_W - LOW_W;
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(1) << ALIGN_BITS;
   localparam logic [ADDR_W-1:0] AMASK  = {ADDR_W{1'b1}} << ALIGN_BITS;

   if (ALIGN_BITS < 0 || ALIGN_BITS >= LOW_W) begin : g_bad_align
      $error("pcl_counter: ALIGN_BITS must lie in [0, LOW_W)");
   end
   if (HI_W < 1) begin : g_bad_hi
      $error("pcl_counter: ADDR_W must exceed LOW_W");
   end

   logic [ADDR_W-1:0] nxt;
   logic [ADDR_W-1:0] pc_d;

   always_comb begin
      unique case (src_i)
         SRC_STEP:   nxt = pc_o + STEP_V;
         SRC_COMMIT: nxt = {commit_hi_i, lo_wdata_i};
         SRC_LOAD:   nxt = load_addr_i;
         default:    nxt = pc_o;
      endcase
   end

   // Alignment variant: mask off the low bits only when alignment is asked for.
   if (ALIGN_BITS > 0) begin : g_align
      assign pc_d = nxt & AMASK;
   end else begin : g_noalign
      assign pc_d = nxt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pc_o <= '0;
      else        pc_o <= pc_d;
   end

   if (ALIGN_BITS > 0) begin : g_align_chk
      AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
         pc_o[ALIGN_BITS-1:0] == '0); // R9
   end

   AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      src_i == SRC_STEP |=> pc_o == $past(pc_o) + STEP_V); // R6
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      src_i == SRC_HOLD |=> $stable(pc_o)); // R10
   AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      src_i == SRC_LOAD |=> pc_o == ($past(load_addr_i) & AMASK)); // R7
   AST_COMMIT_HI: assert property (@(posedge clk) disable iff (!rst_n)
      src_i == SRC_COMMIT |=> pc_o[ADDR_W-1:LOW_W] == $past(commit_hi_i)); // R3
endmodule

// File: rtl/pc_latch_unit.sv
module pc_latch_unit
   import pcl_pkg::*;
#(
   parameter int ADDR_W     = 21,
   parameter int LOW_W      = 8,
   parameter int MID_W      = 8,
   parameter int ALIGN_BITS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_rd_i,
   input  logic              lo_wr_i,
   input  logic [LOW_W-1:0]  lo_wdata_i,
   input  logic              mid_latch_wr_i,
   input  logic              up_latch_wr_i,
   input  logic [LOW_W-1:0]  latch_wdata_i,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_addr_i,
   input  logic              adv_i,
   output logic [ADDR_W-1:0] fetch_addr_o,
   output logic [LOW_W-1:0]  lo_rdata_o
);
   localparam int UP_W  = ADDR_W - LOW_W - MID_W;
   localparam int MID_L = LOW_W;
   localparam int UP_L  = LOW_W + MID_W;

   if (UP_W < 1 || UP_W > LOW_W) begin : g_bad_up
      $error("pc_latch_unit: top field width must lie in [1, LOW_W]");
   end
   if (MID_W < 1 || MID_W > LOW_W) begin : g_bad_mid
      $error("pc_latch_unit: MID_W must lie in [1, LOW_W]");
   end

   pcl_src_e          src;
   logic [MID_W-1:0]  mid_q;
   logic [UP_W-1:0]   up_q;
   logic [ADDR_W-1:0] pc;

   pcl_src_sel u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_i),
      .lo_wr_i (lo_wr_i),
      .adv_i   (adv_i),
      .src_o   (src)
   );

   pcl_shadow_lane #(.W(MID_W)) u_mid (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (mid_latch_wr_i),
      .wdata_i    (latch_wdata_i[MID_W-1:0]),
      .cap_i      (lo_rd_i),
      .cap_data_i (pc[MID_L+MID_W-1:MID_L]),
      .q_o        (mid_q)
   );

   pcl_shadow_lane #(.W(UP_W)) u_up (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (up_latch_wr_i),
      .wdata_i    (latch_wdata_i[UP_W-1:0]),
      .cap_i      (lo_rd_i),
      .cap_data_i (pc[ADDR_W-1:UP_L]),
      .q_o        (up_q)
   );

   pcl_counter #(
      .ADDR_W     (ADDR_W),
      .LOW_W      (LOW_W),
      .ALIGN_BITS (ALIGN_BITS)
   ) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .src_i       (src),
      .load_addr_i (load_addr_i),
      .commit_hi_i ({up_q, mid_q}),
      .lo_wdata_i  (lo_wdata_i),
      .pc_o        (pc)
   );

   assign fetch_addr_o = pc;
   assign lo_rdata_o   = pc[LOW_W-1:0];

   AST_LOAD_SKIPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !lo_rd_i && !mid_latch_wr_i && !up_latch_wr_i)
      |=> ($stable(mid_q) && $stable(up_q))); // R7
   AST_LATCH_ONLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((mid_latch_wr_i || up_latch_wr_i) && !load_i && !lo_wr_i && !adv_i)
      |=> $stable(fetch_addr_o)); // R4
endmodule

// File: tb/tb_pc_latch_unit.sv
`timescale 1ns/1ps
module tb_pc_latch_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lo_rd_i = 0, lo_wr_i = 0, mid_latch_wr_i = 0, up_latch_wr_i = 0;
   logic        load_i = 0, adv_i = 0;
   logic [7:0]  lo_wdata_i = 0, latch_wdata_i = 0;
   logic [20:0] load_addr_i = 0;
   logic [20:0] fetch_addr_o;
   logic [7:0]  lo_rdata_o;

   int n_tests = 0, n_fail = 0;
   int m_pc = 0, m_mid = 0, m_up = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pc_latch_unit dut (
      .clk(clk), .rst_n(rst_n), .lo_rd_i(lo_rd_i), .lo_wr_i(lo_wr_i),
      .lo_wdata_i(lo_wdata_i), .mid_latch_wr_i(mid_latch_wr_i),
      .up_latch_wr_i(up_latch_wr_i), .latch_wdata_i(latch_wdata_i),
      .load_i(load_i), .load_addr_i(load_addr_i), .adv_i(adv_i),
      .fetch_addr_o(fetch_addr_o), .lo_rdata_o(lo_rdata_o)
   );

   task automatic check(input string tag);
      n_tests++;
      if (int'(fetch_addr_o) != m_pc) begin
         n_fail++;
         $display("FAIL %s fetch_addr actual=%06h expected=%06h", tag, fetch_addr_o, m_pc);
      end
      n_tests++;
      if (int'(lo_rdata_o) != (m_pc & 'hFF)) begin
         n_fail++;
         $display("FAIL R2 lo_rdata actual=%02h expected=%02h", lo_rdata_o, m_pc & 'hFF);
      end
   endtask

   // Drive one cycle of stimulus, update the reference model at the edge, check after it.
   task automatic step(input bit ld, input int la, input bit wr, input int wd,
                       input bit mw, input bit uw, input int ldat,
                       input bit rd, input bit av, input string tag);
      int nm, nu, np;
      load_i = ld; load_addr_i = 21'(la); lo_wr_i = wr; lo_wdata_i = 8'(wd);
      mid_latch_wr_i = mw; up_latch_wr_i = uw; latch_wdata_i = 8'(ldat);
      lo_rd_i = rd; adv_i = av;
      @(posedge clk);
      nm = m_mid; nu = m_up; np = m_pc;
      if (rd) begin nm = (m_pc >> 8) & 'hFF; nu = (m_pc >> 16) & 'h1F; end
      if (mw) nm = ldat & 'hFF;
      if (uw) nu = ldat & 'h1F;
      if (ld)      np = la & 'h1FFFFE;
      else if (wr) np = (m_up << 16) | (m_mid << 8) | (wd & 'hFE);
      else if (av) np = (m_pc + 2) & 'h1FFFFF;
      m_pc = np; m_mid = nm; m_up = nu;
      @(negedge clk);
      check(tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1");
      step(0,0,1,'h41,0,0,0,0,0,"R1");           // latches were zero
      step(0,0,0,0,0,0,0,0,1,"R6");
      step(0,0,0,0,0,0,0,0,1,"R6");
      step(0,0,0,0,1,0,'h12,0,0,"R4");           // latch write alone: no move
      step(0,0,0,0,0,1,'hFA,0,0,"R4");           // top latch keeps 5 bits
      step(0,0,1,'h35,0,0,0,0,0,"R3");           // -> 0x1A1234
      step(1,'h0ABCDF,0,0,0,0,0,0,0,"R7");       // odd target aligned
      step(0,0,1,'h10,0,0,0,0,0,"R7");           // latches untouched by load
      step(1,'h155502,0,0,0,0,0,0,0,"R7");
      step(0,0,0,0,0,0,0,1,0,"R5");              // capture 0x15 / 0x55
      step(0,0,1,'h00,0,0,0,0,0,"R5");
      step(0,0,0,0,1,0,'h77,1,0,"R5");           // write beats capture
      step(0,0,1,'h09,0,0,0,0,0,"R9");
      step(1,'h001000,1,'h44,0,0,0,0,1,"R8");
      step(0,0,1,'h44,0,0,0,0,1,"R8");
      step(1,'h1FFFFE,0,0,0,0,0,0,0,"R7");
      step(0,0,0,0,0,0,0,0,1,"R6");              // wraps to 0
      step(0,0,0,0,0,0,0,0,0,"R10");
      step(0,0,0,0,0,0,0,1,0,"R10");
      for (int i = 0; i < 400; i++) begin
         int r = int'($urandom);
         step(r[0] & r[1], int'($urandom), r[2], int'($urandom), r[3] & r[4],
              r[5] & r[6], int'($urandom), r[7], r[8] | r[9], "R8");
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule